// File: doc/BRIEF.md
# Mailbox Boot Upload Receiver

This block sits on the audio-processor side of a four-port mailbox and does the work of the boot loader in hardware. After reset it shows a fixed two-byte ready pattern to the host. It then waits for a kick. When the kick arrives, it reads a command and a 16-bit destination address from the other ports. It collects a stream of data bytes and writes them into a 64 KiB audio RAM through a plain write port.

Each data byte is handshaken: the host places the byte on port 1 and then moves a running counter on port 0. The block stores the byte and echoes the counter back. Any other change on port 0 ends the current block. At that point the command on port 1 either opens a new block at a fresh address (non-zero) or asks for a jump (zero). A jump produces a one-cycle start pulse with the entry address held steady. The block then stops until reset.

Top module: `boot_upload_rx`

## Requirements
- R1: After reset, `dev_p0` reads AAh, `dev_p1` reads BBh, and both `ram_we` and `start_pulse` are low.
- R2: In the ready state, if `host_p0` equals CCh and `host_p1` is non-zero, then one cycle later `dev_p0` echoes CCh, `dev_p1` drops to 00h, and nothing is written.
- R3: While a block is open and `host_p0` equals the value currently echoed on `dev_p0`, no RAM write happens and `dev_p0` does not change.
- R4: Inside a block, the expected counter starts at 00h and advances by one per byte. When `host_p0` equals the expected counter, then one cycle later `ram_we` is high for exactly one cycle with `ram_wdata` equal to `host_p1`, and `dev_p0` echoes the counter.
- R5: The first byte of a block is written to {`host_p3`,`host_p2`} as captured when the block opened (`host_p3` is the high byte). Each further byte goes to the next address, and the address wraps from FFFFh to 0000h.
- R6: Inside a block, a `host_p0` value that is neither the echoed value nor the expected counter ends the block. If `host_p1` is non-zero at that time, a new block opens at the address on ports 3/2, the counter restarts at 00h, and `dev_p0` echoes the new `host_p0` value with no write.
- R7: If a block ends with `host_p1` equal to zero, then one cycle later `start_pulse` is high for exactly one cycle, `entry_addr` equals {`host_p3`,`host_p2`}, and `dev_p0` echoes `host_p0`.
- R8: After the start pulse, the block makes no further writes and no further pulses, `entry_addr` stays constant, and `dev_p0` ignores port activity until reset.
- R9: A kick (CCh) in the ready state with `host_p1` equal to zero jumps at once, as in R7, with `dev_p0` echoing CCh.
- R10: In the ready state, `host_p0` values other than CCh have no effect: AAh/BBh stay on the outputs and no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_p0 | input | 8 | Host kick / byte counter |
| host_p1 | input | 8 | Host command or data byte |
| host_p2 | input | 8 | Host address low byte |
| host_p3 | input | 8 | Host address high byte |
| dev_p0 | output | 8 | Ready pattern low / echo to host |
| dev_p1 | output | 8 | Ready pattern high (00h once busy) |
| ram_addr | output | 16 | Audio RAM write address |
| ram_wdata | output | 8 | Audio RAM write data |
| ram_we | output | 1 | Audio RAM write enable (one cycle per byte) |
| start_pulse | output | 1 | One-cycle jump request |
| entry_addr | output | 16 | Jump target, stable after the pulse |

## Verification
The main handshake is run with three kinds of port-0 change inside a block: repeating the echoed value, which must stall; stepping to the expected counter, which must store exactly one byte; and skipping ahead, which must close the block. The skip is tried with a non-zero and with a zero command. This separates opening a new block from jumping. A block placed at FFFEh shows whether the address wraps or carries into a wider counter. The sequences with a kick that carries a zero command, and with non-kick values in the ready state, show whether the ready state decodes only CCh.

// File: rtl/upl_pkg.sv
package upl_pkg;
   typedef enum logic [1:0] {
      UPL_READY = 2'd0,
      UPL_BLOCK = 2'd1,
      UPL_HALT  = 2'd2
   } upl_st_e;
endpackage

// File: rtl/upl_in_sync.sv
module upl_in_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= d;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/upl_step.sv
module upl_step #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] cnt_in,
   input  logic [W-1:0] echo,
   input  logic [W-1:0] expect_cnt,
   output logic         hold,
   output logic         advance,
   output logic         finish
);
   always_comb begin
      hold    = (cnt_in == echo);
      advance = !hold && (cnt_in == expect_cnt);
      finish  = !hold && !advance;
   end
endmodule

// File: rtl/upl_addr_ctr.sv
module upl_addr_ctr #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_val;
      else if (inc)  q <= q + 1'b1;
   end
endmodule

// File: rtl/boot_upload_rx.sv
module boot_upload_rx
   import upl_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned SYNC_STAGES = 0,
   parameter logic [7:0]  READY_LO    = 8'hAA,
   parameter logic [7:0]  READY_HI    = 8'hBB,
   parameter logic [7:0]  KICK        = 8'hCC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] host_p0,
   input  logic [DATA_W-1:0] host_p1,
   input  logic [DATA_W-1:0] host_p2,
   input  logic [DATA_W-1:0] host_p3,
   output logic [DATA_W-1:0] dev_p0,
   output logic [DATA_W-1:0] dev_p1,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              ram_we,
   output logic              start_pulse,
   output logic [ADDR_W-1:0] entry_addr
);
   localparam int unsigned BUS_W = 4 * DATA_W;

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("ADDR_W must be twice DATA_W");
      end
      if (DATA_W != 8) begin : g_bad_data
         $error("DATA_W must be 8 for the fixed signature bytes");
      end
   endgenerate

   logic [BUS_W-1:0]  raw_bus, sync_bus;
   logic [DATA_W-1:0] p0s, p1s, p2s, p3s;

   assign raw_bus = {host_p3, host_p2, host_p1, host_p0};

   upl_in_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
   );

   assign p0s = sync_bus[DATA_W-1:0];
   assign p1s = sync_bus[2*DATA_W-1:DATA_W];
   assign p2s = sync_bus[3*DATA_W-1:2*DATA_W];
   assign p3s = sync_bus[4*DATA_W-1:3*DATA_W];

   upl_st_e           st_q;
   logic [DATA_W-1:0] echo_q, exp_q;
   logic [ADDR_W-1:0] cur_addr;
   logic              step_hold, step_adv, step_fin;
   logic              go_ready, adv, fin, reeval, new_blk, jump;
   logic [ADDR_W-1:0] dest;

   upl_step #(.W(DATA_W)) u_step (
      .cnt_in(p0s), .echo(echo_q), .expect_cnt(exp_q),
      .hold(step_hold), .advance(step_adv), .finish(step_fin)
   );

   always_comb begin
      dest     = {p3s, p2s};
      go_ready = (st_q == UPL_READY) && (p0s == KICK);
      adv      = (st_q == UPL_BLOCK) && step_adv;
      fin      = (st_q == UPL_BLOCK) && step_fin;
      reeval   = go_ready || fin;
      new_blk  = reeval && (p1s != '0);
      jump     = reeval && (p1s == '0);
   end

   upl_addr_ctr #(.W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(new_blk), .load_val(dest),
      .inc(adv), .q(cur_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= UPL_READY;
         echo_q      <= READY_LO;
         exp_q       <= '0;
         ram_we      <= 1'b0;
         ram_wdata   <= '0;
         ram_addr    <= '0;
         start_pulse <= 1'b0;
         entry_addr  <= '0;
      end else begin
         ram_we      <= adv;
         start_pulse <= jump;
         if (adv) begin
            ram_wdata <= p1s;
            ram_addr  <= cur_addr;
            echo_q    <= p0s;
            exp_q     <= exp_q + 1'b1;
         end
         if (reeval) begin
            echo_q <= p0s;
            exp_q  <= '0;
         end
         if (new_blk) st_q <= UPL_BLOCK;
         if (jump) begin
            st_q       <= UPL_HALT;
            entry_addr <= dest;
         end
      end
   end

   assign dev_p0 = echo_q;
   assign dev_p1 = (st_q == UPL_READY) ? READY_HI : '0;
endmodule

// File: rtl/boot_upload_rx_chk.sv
module boot_upload_rx_chk
   import upl_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 16,
   parameter logic [7:0]  READY_LO = 8'hAA,
   parameter logic [7:0]  READY_HI = 8'hBB
) (
   input logic              clk,
   input logic              rst_n,
   input upl_st_e           st,
   input logic [DATA_W-1:0] dev_p0,
   input logic [DATA_W-1:0] dev_p1,
   input logic [ADDR_W-1:0] ram_addr,
   input logic              ram_we,
   input logic              start_pulse,
   input logic [ADDR_W-1:0] entry_addr
);
   AST_READY_SIGNATURE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == UPL_READY) |-> (dev_p0 == READY_LO && dev_p1 == READY_HI)); // R1
   AST_WRITE_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ($past(st) == UPL_BLOCK)); // R4
   AST_WRITE_ECHO_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (dev_p0 != $past(dev_p0))); // R4
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + 1'b1)); // R5
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse); // R7
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == UPL_HALT) |=> (st == UPL_HALT && !ram_we)); // R8
   AST_ENTRY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == UPL_HALT && !start_pulse) |-> $stable(entry_addr)); // R8
   AST_NO_WRITE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_pulse && ram_we)); // R7
endmodule

bind boot_upload_rx boot_upload_rx_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .READY_LO(READY_LO), .READY_HI(READY_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .st(st_q), .dev_p0(dev_p0), .dev_p1(dev_p1),
   .ram_addr(ram_addr), .ram_we(ram_we), .start_pulse(start_pulse),
   .entry_addr(entry_addr)
);

// File: tb/sim_boot_upload_rx.sv
`timescale 1ns/1ps
module sim_boot_upload_rx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  host_p0 = '0, host_p1 = '0, host_p2 = '0, host_p3 = '0;
   logic [7:0]  dev_p0, dev_p1, ram_wdata;
   logic [15:0] ram_addr, entry_addr;
   logic        ram_we, start_pulse;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   boot_upload_rx u0 (
      .clk(clk), .rst_n(rst_n), .host_p0(host_p0), .host_p1(host_p1),
      .host_p2(host_p2), .host_p3(host_p3), .dev_p0(dev_p0), .dev_p1(dev_p1),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
      .start_pulse(start_pulse), .entry_addr(entry_addr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      host_p0 = '0; host_p1 = '0; host_p2 = '0; host_p3 = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] cnt, input logic [7:0] data, input logic [15:0] addr);
      @(negedge clk) host_p1 = data;
      @(negedge clk) host_p0 = cnt;
      @(negedge clk);
      chk("R4 we", ram_we, 1'b1);
      chk("R4 wdata", ram_wdata, data);
      chk("R4 echo", dev_p0, cnt);
      chk("R5 addr", ram_addr, addr);
      @(negedge clk);
      chk("R4 single-cycle we", ram_we, 1'b0);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 p0", dev_p0, 8'hAA);
      chk("R1 p1", dev_p1, 8'hBB);
      chk("R1 we", ram_we, 1'b0);
      chk("R1 start", start_pulse, 1'b0);
   endtask

   task automatic t_ready_ignore();
      @(negedge clk) host_p1 = 8'h01;
      @(negedge clk) host_p0 = 8'h55;
      repeat (3) @(negedge clk);
      chk("R10 p0", dev_p0, 8'hAA);
      chk("R10 p1", dev_p1, 8'hBB);
      chk("R10 we", ram_we, 1'b0);
   endtask

   task automatic t_kick();
      @(negedge clk) begin host_p2 = 8'h00; host_p3 = 8'h02; host_p1 = 8'h01; end
      @(negedge clk) host_p0 = 8'hCC;
      @(negedge clk);
      chk("R2 echo", dev_p0, 8'hCC);
      chk("R2 p1", dev_p1, 8'h00);
      chk("R2 we", ram_we, 1'b0);
   endtask

   task automatic t_hold();
      @(negedge clk) host_p1 = 8'h77;
      repeat (4) @(negedge clk) chk("R3 no write", ram_we, 1'b0);
      chk("R3 echo", dev_p0, 8'hCC);
   endtask

   task automatic t_bytes();
      for (int i = 0; i < 3; i++) send_byte(8'(i), 8'h10 + 8'(i), 16'h0200 + 16'(i));
   endtask

   task automatic t_new_block();
      @(negedge clk) begin host_p2 = 8'hFE; host_p3 = 8'hFF; host_p1 = 8'h05; end
      @(negedge clk) host_p0 = 8'h05;
      @(negedge clk);
      chk("R6 echo", dev_p0, 8'h05);
      chk("R6 we", ram_we, 1'b0);
      chk("R6 start", start_pulse, 1'b0);
      send_byte(8'h00, 8'hA0, 16'hFFFE);
      send_byte(8'h01, 8'hA1, 16'hFFFF);
      send_byte(8'h02, 8'hA2, 16'h0000);
   endtask

   task automatic t_jump();
      @(negedge clk) begin host_p2 = 8'h34; host_p3 = 8'h12; host_p1 = 8'h00; end
      @(negedge clk) host_p0 = 8'h04;
      @(negedge clk);
      chk("R7 start", start_pulse, 1'b1);
      chk("R7 entry", entry_addr, 16'h1234);
      chk("R7 echo", dev_p0, 8'h04);
      chk("R7 we", ram_we, 1'b0);
      @(negedge clk);
      chk("R7 pulse width", start_pulse, 1'b0);
   endtask

   task automatic t_halt();
      @(negedge clk) begin host_p1 = 8'h09; host_p2 = 8'h00; host_p3 = 8'h00; end
      @(negedge clk) host_p0 = 8'h05;
      repeat (3) @(negedge clk) begin
         chk("R8 we", ram_we, 1'b0);
         chk("R8 start", start_pulse, 1'b0);
      end
      @(negedge clk) host_p1 = 8'h00;
      @(negedge clk) host_p0 = 8'h40;
      repeat (2) @(negedge clk);
      chk("R8 start after zero cmd", start_pulse, 1'b0);
      chk("R8 entry", entry_addr, 16'h1234);
      chk("R8 echo", dev_p0, 8'h04);
   endtask

   task automatic t_direct_entry();
      do_reset();
      @(negedge clk) begin host_p2 = 8'h00; host_p3 = 8'h80; host_p1 = 8'h00; end
      @(negedge clk) host_p0 = 8'hCC;
      @(negedge clk);
      chk("R9 start", start_pulse, 1'b1);
      chk("R9 entry", entry_addr, 16'h8000);
      chk("R9 echo", dev_p0, 8'hCC);
      chk("R9 we", ram_we, 1'b0);
   endtask

   initial begin
      t_reset();
      t_ready_ignore();
      t_kick();
      t_hold();
      t_bytes();
      t_new_block();
      t_jump();
      t_halt();
      t_direct_entry();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule